// File: doc/BRIEF.md
# Configurable SPI Master Engine

This block runs one SPI exchange at a time. A host loads a transmit word of up to 16 bits, a bit count, a control byte, a clock divider and a target index, then pulses `start_i` for one cycle. The engine generates the serial clock from the system clock and asserts one of eight active-low selects. It shifts the chosen number of bits out on MOSI and samples the same number from MISO. When the last edge has gone by, it drops `busy_o` and shows the received bits, right-aligned, on `rx_data_o`.

The control byte selects the SPI mode (clock phase and idle polarity) and the shift order. It also sets a free-running serial clock and a separate polarity inversion for each of the four serial lines. All settings are captured when a transfer is accepted, so the inputs may change while it runs. While the engine is idle, the live control byte and divider set the pin levels and the free-running clock. The control and status pins are plain levels and pulses. The block has no data stream and no back-pressure: a request either starts a transfer or is dropped.

Top module: `spi_master_engine`

## Requirements
- R1: After reset `busy_o` is 0, `rx_data_o` is 0, every `ss_n_o` line is high (with control byte 0) and `sclk_o` rests at its idle level.
- R2: A `start_i` pulse while idle with a non-zero length raises `busy_o` on the next cycle. A length of 0 is ignored and `busy_o` stays low.
- R3: A length above 16 is treated as 16.
- R4: Without free-run, the serial clock toggles once every (divider+1) system cycles, and `busy_o` stays high for exactly 2·N·(divider+1) cycles for an N-bit transfer.
- R5: Control bit 0 is the clock phase and bit 1 the idle polarity. With phase 0, MISO is sampled on the leading edge of each bit and MOSI changes on the trailing edge. With phase 1, MOSI changes on leading edges and MISO is sampled on trailing edges. The clock rests at the polarity value.
- R6: Control bit 2 sets the order. At 0 the bits go MSB first, from bit N-1 down to bit 0. At 1 they go LSB first, from bit 0 up. Received bits land at the same positions and bits N and above read 0.
- R7: The low 3 bits of the target field pick the select line to drive. Only that line is low, and only during shifting. All other lines stay high, and every line is high outside shifting.
- R8: Control bits 4, 5, 6 and 7 invert the serial clock, the selects, MOSI and MISO, in that order. Each takes effect at the pin. With bit 4 set the clock rests at the opposite of the polarity bit.
- R9: Control bit 3 enables free-run. The serial clock keeps toggling while idle. After an accepted start, selection and shifting begin at the first clock toggle that returns the clock to its rest level, and `busy_o` is high from acceptance onward.
- R10: A `start_i` that arrives while `busy_o` is high has no effect on the running transfer. `rx_data_o` holds its value until the next transfer completes.
- R11: Transmit word, length, control byte, divider and target are captured at acceptance. Changing them during a transfer does not change it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | One-cycle transfer request |
| tx_data_i | input | 16 | Word to transmit |
| len_i | input | 8 | Bit count (0 = none, above 16 = 16) |
| ctrl_i | input | 8 | Mode, order, free-run and inversion bits |
| clk_div_i | input | 8 | Serial clock divider |
| target_i | input | 8 | Select index (low 3 bits used) |
| busy_o | output | 1 | Transfer in progress |
| rx_data_o | output | 16 | Last received word, right-aligned |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| ss_n_o | output | 8 | Slave selects |

## Verification
The bench drives MISO with a fresh pseudo-random bit every cycle. Sampling one cycle early or late, or on the wrong edge for a given phase, therefore shows up as a changed received word. Lengths of 0, 1 and 20 are used to catch a counter that runs away, misses the clamp or leaves stale upper bits. Mode and inversion mixes catch an idle level that ignores clock inversion, or a select that is active outside shifting. Free-run starts at both clock phases catch an engine that begins on the wrong toggle. Mid-transfer changes to the inputs and a second start catch configuration that is not latched and restarts that are not suppressed.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;
  typedef struct packed {
    logic miso_inv;
    logic mosi_inv;
    logic ss_inv;
    logic sck_inv;
    logic free_run;
    logic lsb_first;
    logic cpol;
    logic cpha;
  } spi_ctrl_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ALIGN = 2'd1,
    ST_SHIFT = 2'd2
  } spi_state_e;
endpackage

// File: rtl/spi_rate_div.sv
module spi_rate_div #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run_i,
  input  logic          clear_i,
  input  logic [CW-1:0] limit_i,
  output logic          tick_o
);
  logic [CW-1:0] cnt;

  assign tick_o = run_i && !clear_i && (cnt == limit_i);

  always_ff @(posedge clk) begin
    if (!rst_n)                 cnt <= '0;
    else if (clear_i || !run_i) cnt <= '0;
    else if (cnt == limit_i)    cnt <= '0;
    else                        cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/spi_bit_pos.sv
module spi_bit_pos #(
  parameter int IDX_W = 5,
  parameter int POS_W = 4
) (
  input  logic [IDX_W-1:0] idx_i,
  input  logic [IDX_W-1:0] len_i,
  input  logic             lsb_first_i,
  output logic [POS_W-1:0] pos_o
);
  logic [IDX_W-1:0] rev;
  logic             unused_rev;

  assign rev        = len_i - idx_i - IDX_W'(1);
  assign unused_rev = ^rev[IDX_W-1:POS_W];
  assign pos_o      = lsb_first_i ? idx_i[POS_W-1:0] : rev[POS_W-1:0];
endmodule

// File: rtl/spi_sel_decode.sv
module spi_sel_decode #(
  parameter int SEL_N = 8,
  parameter int SEL_W = 3
) (
  input  logic [SEL_W-1:0] idx_i,
  input  logic             enable_i,
  input  logic             invert_i,
  output logic [SEL_N-1:0] sel_n_o
);
  for (genvar g = 0; g < SEL_N; g++) begin : g_line
    assign sel_n_o[g] = ~(enable_i && (idx_i == SEL_W'(g))) ^ invert_i;
  end
endmodule

// File: rtl/spi_master_engine.sv
module spi_master_engine #(
  parameter int DATA_W = 16,
  parameter int LEN_W  = 8,
  parameter int DIV_W  = 8,
  parameter int SEL_N  = 8,
  parameter int TGT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [7:0]        ctrl_i,
  input  logic [DIV_W-1:0]  clk_div_i,
  input  logic [TGT_W-1:0]  target_i,
  output logic              busy_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              sclk_o,
  output logic              mosi_o,
  input  logic              miso_i,
  output logic [SEL_N-1:0]  ss_n_o
);
  import spi_eng_pkg::*;

  localparam int POS_W  = $clog2(DATA_W);
  localparam int IDX_W  = POS_W + 1;
  localparam int ECNT_W = IDX_W + 1;
  localparam int SEL_W  = $clog2(SEL_N);

  spi_state_e        state;
  spi_ctrl_t         ctrl_live, ctrl_q, ctrl_eff;
  logic [DATA_W-1:0] tx_q, acc_q, acc_nx, rx_q;
  logic [IDX_W-1:0]  len_q, len_clamp, out_idx, in_idx;
  logic [ECNT_W-1:0] ecnt, ecnt_m1, last_edge;
  logic [DIV_W-1:0]  div_q, div_lim;
  logic [SEL_W-1:0]  tgt_q;
  logic [POS_W-1:0]  out_pos, in_pos;
  logic              phase, run, tick, accept, shifting, samp_edge, miso_eff;
  logic              unused_bits;

  assign ctrl_live   = spi_ctrl_t'(ctrl_i);
  assign busy_o      = (state != ST_IDLE);
  assign shifting    = (state == ST_SHIFT);
  assign ctrl_eff    = busy_o ? ctrl_q : ctrl_live;
  assign run         = busy_o || ctrl_live.free_run;
  assign div_lim     = busy_o ? div_q : clk_div_i;
  assign accept      = !busy_o && start_i && (len_i != '0);
  assign len_clamp   = (len_i > LEN_W'(DATA_W)) ? IDX_W'(DATA_W) : len_i[IDX_W-1:0];
  assign last_edge   = {len_q, 1'b0} - ECNT_W'(1);
  assign ecnt_m1     = ecnt - ECNT_W'(1);
  assign samp_edge   = (ecnt[0] == ctrl_q.cpha);
  assign in_idx      = ecnt[ECNT_W-1:1];
  assign out_idx     = !ctrl_q.cpha ? ecnt[ECNT_W-1:1] :
                       (ecnt == '0) ? '0 : ecnt_m1[ECNT_W-1:1];
  assign miso_eff    = miso_i ^ ctrl_q.miso_inv;
  assign unused_bits = ^{target_i, ecnt_m1[0]};

  spi_rate_div #(.CW(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .run_i(run), .clear_i(accept),
    .limit_i(div_lim), .tick_o(tick)
  );

  spi_bit_pos #(.IDX_W(IDX_W), .POS_W(POS_W)) u_opos (
    .idx_i(out_idx), .len_i(len_q), .lsb_first_i(ctrl_q.lsb_first), .pos_o(out_pos)
  );

  spi_bit_pos #(.IDX_W(IDX_W), .POS_W(POS_W)) u_ipos (
    .idx_i(in_idx), .len_i(len_q), .lsb_first_i(ctrl_q.lsb_first), .pos_o(in_pos)
  );

  spi_sel_decode #(.SEL_N(SEL_N), .SEL_W(SEL_W)) u_sel (
    .idx_i(tgt_q), .enable_i(shifting), .invert_i(ctrl_eff.ss_inv), .sel_n_o(ss_n_o)
  );

  always_comb begin
    acc_nx = acc_q;
    if (shifting && tick && samp_edge) acc_nx[in_pos] = miso_eff;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      ctrl_q <= '0;
      tx_q   <= '0;
      len_q  <= '0;
      div_q  <= '0;
      tgt_q  <= '0;
      ecnt   <= '0;
      acc_q  <= '0;
      rx_q   <= '0;
      phase  <= 1'b0;
    end else begin
      if (!run)      phase <= 1'b0;
      else if (tick) phase <= ~phase;
      case (state)
        ST_IDLE: if (accept) begin
          ctrl_q <= ctrl_live;
          tx_q   <= tx_data_i;
          len_q  <= len_clamp;
          div_q  <= clk_div_i;
          tgt_q  <= target_i[SEL_W-1:0];
          ecnt   <= '0;
          acc_q  <= '0;
          state  <= ctrl_live.free_run ? ST_ALIGN : ST_SHIFT;
        end
        ST_ALIGN: if (tick && phase) begin
          state <= ST_SHIFT;
          ecnt  <= '0;
        end
        ST_SHIFT: if (tick) begin
          acc_q <= acc_nx;
          ecnt  <= ecnt + 1'b1;
          if (ecnt == last_edge) begin
            state <= ST_IDLE;
            rx_q  <= acc_nx;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign rx_data_o = rx_q;
  assign sclk_o    = phase ^ ctrl_eff.cpol ^ ctrl_eff.sck_inv;
  assign mosi_o    = (shifting & tx_q[out_pos]) ^ ctrl_eff.mosi_inv;

  AST_ZERO_LEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && start_i && len_i == '0) |=> !busy_o); // R2
  AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && start_i && len_i != '0) |=> busy_o); // R2
  AST_RX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(busy_o) |-> $stable(rx_data_o)); // R10
  AST_ONE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    shifting |-> $countones(ss_n_o ^ {SEL_N{~ctrl_eff.ss_inv}}) == 1); // R7
  AST_NO_SELECT_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_n)
    !shifting |-> ss_n_o == {SEL_N{~ctrl_eff.ss_inv}}); // R7
  AST_SCK_REST: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !ctrl_i[3] && $past(!busy_o && !ctrl_i[3])) |-> sclk_o == (ctrl_i[1] ^ ctrl_i[4])); // R5
  AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o)) |-> ($stable(tx_q) && $stable(ctrl_q) && $stable(len_q))); // R11
endmodule

// File: tb/sim_spi_master_engine.sv
`timescale 1ns/1ps
module sim_spi_master_engine;
  logic        clk = 1'b0, rst_n = 1'b0, start = 1'b0, miso = 1'b0;
  logic [15:0] tx = '0;
  logic [7:0]  len = '0, ctrl = '0, div = '0, tgt = '0;
  logic        busy, sclk, mosi;
  logic [15:0] rx;
  logic [7:0]  ssn;

  spi_master_engine u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start), .tx_data_i(tx), .len_i(len),
    .ctrl_i(ctrl), .clk_div_i(div), .target_i(tgt), .busy_o(busy),
    .rx_data_o(rx), .sclk_o(sclk), .mosi_o(mosi), .miso_i(miso), .ss_n_o(ssn)
  );

  always #4 clk = ~clk;

  int total = 0, bad = 0, busy_cnt = 0;
  bit done = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  // behavioural reference
  int m_st = 0, m_cnt = 0, m_e = 0, m_n = 1, m_div = 0, m_tgt = 0, m_oi = 0, lim;
  bit m_ph = 1'b0, run;
  logic [7:0]  m_c = '0;
  logic [15:0] m_tx = '0, m_acc = '0, m_rxo = '0;

  function automatic int mpos(int i);
    return m_c[2] ? i : m_n - 1 - i;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_cnt = 0; m_ph = 1'b0; m_rxo = '0; m_c = '0;
    end else begin
      lim = (m_st != 0) ? m_div : int'(div);
      run = (m_st != 0) || ctrl[3];
      case (m_st)
        0: if (start && len != 0) begin
             m_c = ctrl; m_tx = tx; m_n = (len > 16) ? 16 : int'(len);
             m_div = int'(div); m_tgt = int'(tgt) % 8;
             m_e = 0; m_oi = 0; m_acc = '0; m_cnt = 0;
             if (!ctrl[3]) m_ph = 1'b0;
             m_st = ctrl[3] ? 1 : 2;
           end else if (run) begin
             if (m_cnt == lim) begin m_cnt = 0; m_ph = !m_ph; end
             else m_cnt = (m_cnt + 1) % 256;
           end else begin
             m_cnt = 0; m_ph = 1'b0;
           end
        1: if (m_cnt == m_div) begin
             m_cnt = 0;
             if (m_ph) begin m_st = 2; m_e = 0; end
             m_ph = !m_ph;
           end else m_cnt++;
        2: if (m_cnt == m_div) begin
             m_cnt = 0; m_ph = !m_ph;
             if ((m_e % 2) == int'(m_c[0])) m_acc[mpos(m_e / 2)] = miso ^ m_c[7];
             else if (m_e != 0) m_oi++;
             m_e++;
             if (m_e == 2 * m_n) begin m_st = 0; m_rxo = m_acc; end
           end else m_cnt++;
        default: ;
      endcase
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step();
    logic [7:0] ce, essn;
    bit e_mosi;
    @(negedge clk);
    if (rst_n) begin
      ce = (m_st != 0) ? m_c : ctrl;
      e_mosi = ((m_st == 2 && m_oi < m_n) ? m_tx[mpos(m_oi)] : 1'b0) ^ ce[6];
      for (int i = 0; i < 8; i++) essn[i] = !(m_st == 2 && i == m_tgt) ^ ce[5];
      chk(busy === (m_st != 0), "R2 busy", {31'b0, busy}, {31'b0, m_st != 0});
      chk(sclk === (m_ph ^ ce[1] ^ ce[4]), "R4 sclk", {31'b0, sclk}, {31'b0, m_ph ^ ce[1] ^ ce[4]});
      chk(mosi === e_mosi, "R6 mosi", {31'b0, mosi}, {31'b0, e_mosi});
      chk(ssn === essn, "R7 select", {24'b0, ssn}, {24'b0, essn});
      chk(rx === m_rxo, "R10 rx", {16'b0, rx}, {16'b0, m_rxo});
      if (busy === 1'b1) busy_cnt++;
    end
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    miso = lfsr[0];
  endtask

  task automatic launch(input [15:0] t, input [7:0] l, input [7:0] c, input [7:0] d, input [7:0] g);
    tx = t; len = l; ctrl = c; div = d; tgt = g; start = 1'b1;
    busy_cnt = 0;
    step();
    start = 1'b0;
  endtask

  task automatic finish(input string tag);
    for (int k = 0; k < 20000 && busy === 1'b1; k++) step();
    chk(rx === m_rxo, tag, {16'b0, rx}, {16'b0, m_rxo});
  endtask

  initial begin
    bit s0;
    repeat (3) step();
    rst_n = 1'b1;
    step();
    chk(busy === 1'b0, "R1 busy", {31'b0, busy}, 0);
    chk(rx === 16'h0, "R1 rx", {16'b0, rx}, 0);
    chk(ssn === 8'hFF, "R1 select", {24'b0, ssn}, 32'hFF);
    chk(sclk === 1'b0, "R1 sclk", {31'b0, sclk}, 0);

    launch(16'h1234, 8'd0, 8'h00, 8'd1, 8'd0);
    step(); step();
    chk(busy === 1'b0, "R2 zero length", {31'b0, busy}, 0);

    launch(16'hA5C3, 8'd8, 8'h00, 8'd1, 8'd0);
    finish("R5 mode0");
    chk(busy_cnt == 32, "R4 busy length", busy_cnt, 32);
    launch(16'h0F3C, 8'd12, 8'h01, 8'd0, 8'd1);
    finish("R5 mode1");
    chk(busy_cnt == 24, "R4 div0 length", busy_cnt, 24);
    launch(16'h0015, 8'd5, 8'h02, 8'd3, 8'd2);
    finish("R5 mode2");
    chk(sclk === 1'b1, "R5 idle high", {31'b0, sclk}, 1);
    launch(16'hBEEF, 8'd16, 8'h03, 8'd2, 8'd3);
    finish("R5 mode3");
    launch(16'h005A, 8'd1, 8'h01, 8'd0, 8'd6);
    finish("R5 single bit");

    launch(16'h0063, 8'd7, 8'h04, 8'd1, 8'd4);
    finish("R6 lsb first");
    chk(rx[15:7] === 9'h0, "R6 upper zero", {23'b0, rx[15:7]}, 0);
    launch(16'hC001, 8'd10, 8'h05, 8'd0, 8'd0);
    finish("R6 lsb mode1");

    launch(16'h9ABC, 8'd20, 8'h00, 8'd0, 8'd0);
    finish("R3 clamp");
    chk(busy_cnt == 32, "R3 clamp length", busy_cnt, 32);

    launch(16'h00F0, 8'd8, 8'h00, 8'd0, 8'hFD);
    step();
    chk(ssn === 8'hDF, "R7 target index", {24'b0, ssn}, 32'hDF);
    finish("R7 transfer");

    launch(16'h3C3C, 8'd9, 8'hF0, 8'd1, 8'd2);
    step();
    chk(ssn === 8'h04, "R8 select inverted", {24'b0, ssn}, 32'h04);
    finish("R8 all inverted");
    chk(sclk === 1'b1, "R8 clock rest inverted", {31'b0, sclk}, 1);
    launch(16'h7E81, 8'd11, 8'hF3, 8'd0, 8'd7);
    finish("R8 inverted mode3");
    ctrl = 8'h00;
    step();

    ctrl = 8'h08; div = 8'd2;
    repeat (7) step();
    s0 = sclk;
    repeat (3) step();
    chk(sclk !== s0, "R9 idle toggling", {31'b0, sclk}, {31'b0, !s0});
    launch(16'h002D, 8'd6, 8'h08, 8'd2, 8'd1);
    finish("R9 free run");
    step();
    launch(16'h0ACE, 8'd12, 8'h0A, 8'd1, 8'd5);
    finish("R9 free run cpol");
    ctrl = 8'h00;
    repeat (3) step();

    launch(16'h0355, 8'd10, 8'h00, 8'd1, 8'd0);
    repeat (5) step();
    tx = 16'hFFFF; len = 8'd3; start = 1'b1;
    step();
    start = 1'b0;
    finish("R10 start ignored");
    chk(busy_cnt == 40, "R10 busy length", busy_cnt, 40);
    repeat (4) step();
    chk(rx === m_rxo, "R10 rx held", {16'b0, rx}, {16'b0, m_rxo});

    launch(16'h01A6, 8'd9, 8'h05, 8'd1, 8'd3);
    repeat (3) step();
    tx = 16'h5555; ctrl = 8'hF2; div = 8'd7; len = 8'd3; tgt = 8'd4;
    finish("R11 latched");
    chk(busy_cnt == 36, "R11 busy length", busy_cnt, 36);
    ctrl = 8'h00;
    step();

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog R2 act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule